// File: doc/BRIEF.md
# Watchdog Timer with Unlock Sequences

This block is a watchdog counter that lives in a slow, always-on clock domain and is programmed over a small word-addressed register bus from a faster processor clock. The counter runs upward from a programmable load value. When it rolls past its all-ones value it raises a reset request for one slow clock and starts again from the load value. Software keeps the system alive by writing a refresh word to a trigger register. Each refresh word must differ from the previous one, so that a stuck write loop cannot keep the watchdog quiet.

Counting can only be switched on or off by writing two fixed magic words, one after the other, to a start/stop register. While the counter runs, the prescaler and load settings are frozen. Every bus write is posted: a per-register toggle handshake carries it into the slow domain, and a matching busy flag stays up until the write has been applied there. The counter value travels back to the bus domain through a second handshake, so a read always returns a coherent snapshot.

Top module: `guard_timer`

## Requirements
- R1: After reset the counter is running and counting up from DEF_LOAD, and the pending register reads 0. Bits 7:0 of the revision register (address 0) read REV_CODE.
- R2: Counting starts only when the low 16 bits of two consecutive writes to start/stop (address 5) are 16'hBBBB and then 16'h4444.
- R3: Counting stops only when the low 16 bits of two consecutive writes to start/stop are 16'hAAAA and then 16'h5555.
- R4: A start/stop write that does not continue a half-completed sequence discards that sequence and leaves the counting state unchanged. A lone second word does nothing.
- R5: The pending register (address 6) holds one busy bit per posted register: bit 0 control, bit 2 load, bit 3 trigger, bit 4 start/stop. A bit rises in the cycle after an accepted write and clears only once the slow-domain handshake has completed. A write to a register whose bit is set is dropped.
- R6: A trigger write (address 4) whose value differs from the last accepted trigger value reloads the counter from the load value. A repeated value has no effect. The remembered value is 0 after reset.
- R7: In the control register (address 1), bit 5 enables the prescaler and bits 4:2 hold the shift value p. With the prescaler enabled the counter advances once every 2^p slow clocks; otherwise it advances on every slow clock.
- R8: Writes to control and to load (address 3) are ignored while the counter is running.
- R9: The counter register (address 2) can be read at any time and returns the slow-domain count.
- R10: On the count step after all ones, the block drives wdt_rst high for exactly one slow clock and reloads the counter from the load value, giving a period of (2^CNT_W − load) steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Processor-side register bus clock |
| slow_clk | input | 1 | Slow counting clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| wdt_rst | output | 1 | Reset request, one slow clock wide, synchronous to slow_clk |

## Verification
The hardest situation to reach from the ports is the wrap from all ones. From the default load it lies thousands of steps away, and the load can only be changed while the counter is stopped. The stimulus therefore stops the counter with the off sequence and writes a load just below all ones. It then issues a fresh trigger word to force the reload, restarts with the on sequence, and times the interval between successive reset pulses in slow clocks, once with the prescaler off and once with it on.

// File: rtl/gt_pkg.sv
package gt_pkg;

   localparam int GT_AW    = 3;
   localparam int GT_DW    = 32;
   localparam int GT_NCH   = 4;
   localparam int GT_PENDW = 5;

   localparam logic [GT_AW-1:0] ADR_REV   = 3'd0;
   localparam logic [GT_AW-1:0] ADR_CTRL  = 3'd1;
   localparam logic [GT_AW-1:0] ADR_COUNT = 3'd2;
   localparam logic [GT_AW-1:0] ADR_LOAD  = 3'd3;
   localparam logic [GT_AW-1:0] ADR_TRIG  = 3'd4;
   localparam logic [GT_AW-1:0] ADR_SS    = 3'd5;
   localparam logic [GT_AW-1:0] ADR_PEND  = 3'd6;

   localparam int CH_CTRL = 0;
   localparam int CH_LOAD = 1;
   localparam int CH_TRIG = 2;
   localparam int CH_SS   = 3;

   localparam logic [15:0] KEY_ON_A  = 16'hBBBB;
   localparam logic [15:0] KEY_ON_B  = 16'h4444;
   localparam logic [15:0] KEY_OFF_A = 16'hAAAA;
   localparam logic [15:0] KEY_OFF_B = 16'h5555;

   typedef enum logic [1:0] {
      SEQ_IDLE     = 2'd0,
      SEQ_ON_HALF  = 2'd1,
      SEQ_OFF_HALF = 2'd2
   } seq_e;

   function automatic logic [GT_AW-1:0] chan_addr(input int ch);
      case (ch)
         CH_CTRL: return ADR_CTRL;
         CH_LOAD: return ADR_LOAD;
         CH_TRIG: return ADR_TRIG;
         default: return ADR_SS;
      endcase
   endfunction

   function automatic int busy_pos(input int ch);
      case (ch)
         CH_CTRL: return 0;
         CH_LOAD: return 2;
         CH_TRIG: return 3;
         default: return 4;
      endcase
   endfunction

endpackage

// File: rtl/gt_sync.sv
module gt_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= din;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/gt_post_chan.sv
module gt_post_chan #(
   parameter int DW    = 32,
   parameter int SYNC  = 2
) (
   input  logic          bus_clk,
   input  logic          slow_clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   output logic          busy,
   output logic          apply,
   output logic [DW-1:0] apply_data
);
   logic          req_tog;
   logic [DW-1:0] hold_q;
   logic          ack_tog;
   logic          ack_b;
   logic          req_s;

   // bus side: capture data and flip the request toggle when idle
   always_ff @(posedge bus_clk or negedge rst_n) begin
      if (!rst_n) begin
         req_tog <= 1'b0;
         hold_q  <= '0;
      end else if (wr_en && !busy) begin
         req_tog <= ~req_tog;
         hold_q  <= wr_data;
      end
   end

   gt_sync #(.W(1), .STAGES(SYNC)) u_ack_sync (
      .clk(bus_clk), .rst_n(rst_n), .din(ack_tog), .dout(ack_b)
   );

   assign busy = req_tog ^ ack_b;

   // slow side: a request edge applies the held word and returns the ack
   gt_sync #(.W(1), .STAGES(SYNC)) u_req_sync (
      .clk(slow_clk), .rst_n(rst_n), .din(req_tog), .dout(req_s)
   );

   always_ff @(posedge slow_clk or negedge rst_n) begin
      if (!rst_n) ack_tog <= 1'b0;
      else        ack_tog <= req_s;
   end

   assign apply      = req_s ^ ack_tog;
   assign apply_data = hold_q;
endmodule

// File: rtl/gt_cnt_mirror.sv
module gt_cnt_mirror #(
   parameter int W    = 32,
   parameter int SYNC = 2
) (
   input  logic         slow_clk,
   input  logic         bus_clk,
   input  logic         rst_n,
   input  logic [W-1:0] cnt_in,
   output logic [W-1:0] cnt_out
);
   logic         req_tog;
   logic [W-1:0] snap_q;
   logic         ack_tog;
   logic         ack_s;
   logic         req_b;

   gt_sync #(.W(1), .STAGES(SYNC)) u_ack_sync (
      .clk(slow_clk), .rst_n(rst_n), .din(ack_tog), .dout(ack_s)
   );

   // a new snapshot is taken only after the previous one was consumed
   always_ff @(posedge slow_clk or negedge rst_n) begin
      if (!rst_n) begin
         req_tog <= 1'b0;
         snap_q  <= '0;
      end else if (req_tog == ack_s) begin
         req_tog <= ~req_tog;
         snap_q  <= cnt_in;
      end
   end

   gt_sync #(.W(1), .STAGES(SYNC)) u_req_sync (
      .clk(bus_clk), .rst_n(rst_n), .din(req_tog), .dout(req_b)
   );

   always_ff @(posedge bus_clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_tog <= 1'b0;
         cnt_out <= '0;
      end else if (req_b != ack_tog) begin
         ack_tog <= req_b;
         cnt_out <= snap_q;
      end
   end
endmodule

// File: rtl/gt_core.sv
module gt_core
   import gt_pkg::*;
#(
   parameter int               CNT_W    = 32,
   parameter int               PTV_W    = 3,
   parameter logic [CNT_W-1:0] DEF_LOAD = '0
) (
   input  logic             slow_clk,
   input  logic             rst_n,
   input  logic             ctrl_ap,
   input  logic [PTV_W:0]   ctrl_d,
   input  logic             load_ap,
   input  logic [CNT_W-1:0] load_d,
   input  logic             trig_ap,
   input  logic [GT_DW-1:0] trig_d,
   input  logic             ss_ap,
   input  logic [15:0]      ss_d,
   output logic             running,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] load_q,
   output logic             rst_req
);
   localparam int PRE_W = (1 << PTV_W) - 1;

   seq_e             seq;
   logic             pre_en;
   logic [PTV_W-1:0] ptv;
   logic [PRE_W-1:0] pre_cnt;
   logic [PRE_W-1:0] pre_lim;
   logic [GT_DW-1:0] last_trig;
   logic             tick;
   logic             fresh_trig;

   assign pre_lim    = PRE_W'((32'd1 << ptv) - 32'd1);
   assign tick       = !pre_en || (pre_cnt == pre_lim);
   assign fresh_trig = trig_ap && (trig_d != last_trig);

   always_ff @(posedge slow_clk or negedge rst_n) begin
      if (!rst_n) begin
         running   <= 1'b1;
         seq       <= SEQ_IDLE;
         load_q    <= DEF_LOAD;
         cnt       <= DEF_LOAD;
         pre_en    <= 1'b0;
         ptv       <= '0;
         pre_cnt   <= '0;
         last_trig <= '0;
         rst_req   <= 1'b0;
      end else begin
         rst_req <= 1'b0;

         if (ctrl_ap && !running) begin
            pre_en <= ctrl_d[PTV_W];
            ptv    <= ctrl_d[PTV_W-1:0];
         end

         if (load_ap && !running) load_q <= load_d;

         if (ss_ap) begin
            if (seq == SEQ_ON_HALF && ss_d == KEY_ON_B) begin
               running <= 1'b1;
               seq     <= SEQ_IDLE;
            end else if (seq == SEQ_OFF_HALF && ss_d == KEY_OFF_B) begin
               running <= 1'b0;
               seq     <= SEQ_IDLE;
            end else if (ss_d == KEY_ON_A) begin
               seq <= SEQ_ON_HALF;
            end else if (ss_d == KEY_OFF_A) begin
               seq <= SEQ_OFF_HALF;
            end else begin
               seq <= SEQ_IDLE;
            end
         end

         if (fresh_trig) begin
            last_trig <= trig_d;
            cnt       <= load_q;
            pre_cnt   <= '0;
         end else if (running) begin
            if (tick) begin
               pre_cnt <= '0;
               if (&cnt) begin
                  cnt     <= load_q;
                  rst_req <= 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end else begin
               pre_cnt <= pre_cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/guard_timer.sv
module guard_timer
   import gt_pkg::*;
#(
   parameter int               CNT_W       = 32,
   parameter int               PTV_W       = 3,
   parameter int               SYNC_STAGES = 2,
   parameter logic [CNT_W-1:0] DEF_LOAD    = 32'hFFFF_F000,
   parameter logic [7:0]       REV_CODE    = 8'h3A
) (
   input  logic             bus_clk,
   input  logic             slow_clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [GT_AW-1:0] bus_addr,
   input  logic [GT_DW-1:0] bus_wdata,
   output logic [GT_DW-1:0] bus_rdata,
   output logic             wdt_rst
);
   localparam int CTRL_LSB = 2;
   localparam int CTRL_MSB = CTRL_LSB + PTV_W;

   if (CNT_W < 16 || CNT_W > GT_DW) begin : g_bad_cnt_w
      $error("guard_timer: CNT_W must lie in 16..32");
   end
   if (PTV_W < 1 || PTV_W > 4) begin : g_bad_ptv_w
      $error("guard_timer: PTV_W must lie in 1..4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("guard_timer: SYNC_STAGES must be at least 2");
   end

   logic [GT_NCH-1:0]   busy_ch;
   logic [GT_NCH-1:0]   apply_v;
   logic [GT_DW-1:0]    apply_d [GT_NCH];
   logic [GT_PENDW-1:0] busy_vec;
   logic                core_running;
   logic [CNT_W-1:0]    core_cnt;
   logic [CNT_W-1:0]    load_q;
   logic [CNT_W-1:0]    cnt_bus;
   logic                ss_apply;
   logic                trig_apply;

   for (genvar ch = 0; ch < GT_NCH; ch++) begin : g_chan
      gt_post_chan #(.DW(GT_DW), .SYNC(SYNC_STAGES)) u_chan (
         .bus_clk   (bus_clk),
         .slow_clk  (slow_clk),
         .rst_n     (rst_n),
         .wr_en     (bus_wr && (bus_addr == chan_addr(ch))),
         .wr_data   (bus_wdata),
         .busy      (busy_ch[ch]),
         .apply     (apply_v[ch]),
         .apply_data(apply_d[ch])
      );
   end

   always_comb begin
      busy_vec = '0;
      for (int ch = 0; ch < GT_NCH; ch++) busy_vec[busy_pos(ch)] = busy_ch[ch];
   end

   assign ss_apply   = apply_v[CH_SS];
   assign trig_apply = apply_v[CH_TRIG];

   gt_core #(.CNT_W(CNT_W), .PTV_W(PTV_W), .DEF_LOAD(DEF_LOAD)) u_core (
      .slow_clk(slow_clk),
      .rst_n   (rst_n),
      .ctrl_ap (apply_v[CH_CTRL]),
      .ctrl_d  (apply_d[CH_CTRL][CTRL_MSB:CTRL_LSB]),
      .load_ap (apply_v[CH_LOAD]),
      .load_d  (apply_d[CH_LOAD][CNT_W-1:0]),
      .trig_ap (trig_apply),
      .trig_d  (apply_d[CH_TRIG]),
      .ss_ap   (ss_apply),
      .ss_d    (apply_d[CH_SS][15:0]),
      .running (core_running),
      .cnt     (core_cnt),
      .load_q  (load_q),
      .rst_req (wdt_rst)
   );

   gt_cnt_mirror #(.W(CNT_W), .SYNC(SYNC_STAGES)) u_mirror (
      .slow_clk(slow_clk),
      .bus_clk (bus_clk),
      .rst_n   (rst_n),
      .cnt_in  (core_cnt),
      .cnt_out (cnt_bus)
   );

   logic unused_bits;
   assign unused_bits = ^{apply_d[CH_CTRL], apply_d[CH_LOAD], apply_d[CH_SS]};

   always_comb begin
      case (bus_addr)
         ADR_REV:   bus_rdata = {24'h0, REV_CODE};
         ADR_COUNT: bus_rdata = GT_DW'(cnt_bus);
         ADR_PEND:  bus_rdata = GT_DW'(busy_vec);
         default:   bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk
   import gt_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input logic                bus_clk,
   input logic                slow_clk,
   input logic                rst_n,
   input logic                bus_wr,
   input logic [GT_AW-1:0]    bus_addr,
   input logic [GT_PENDW-1:0] busy_vec,
   input logic                ss_apply,
   input logic                trig_apply,
   input logic                core_running,
   input logic [CNT_W-1:0]    core_cnt,
   input logic [CNT_W-1:0]    load_q,
   input logic                wdt_rst
);
   // R5
   trig_busy_rise_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADR_TRIG && !busy_vec[3]) |=> busy_vec[3]);

   // R5
   busy_needs_write_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
      !bus_wr |=> ($countones(busy_vec) <= $countones($past(busy_vec))));

   // R4
   run_state_hold_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
      !ss_apply |=> $stable(core_running));

   // R2
   count_frozen_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
      (!core_running && !trig_apply) |=> $stable(core_cnt));

   // R10
   rst_pulse_width_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
      (wdt_rst && !(&load_q)) |=> !wdt_rst);

   // R10
   rst_while_running_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
      $rose(wdt_rst) |-> $past(core_running));
endmodule

bind guard_timer guard_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .bus_clk     (bus_clk),
   .slow_clk    (slow_clk),
   .rst_n       (rst_n),
   .bus_wr      (bus_wr),
   .bus_addr    (bus_addr),
   .busy_vec    (busy_vec),
   .ss_apply    (ss_apply),
   .trig_apply  (trig_apply),
   .core_running(core_running),
   .core_cnt    (core_cnt),
   .load_q      (load_q),
   .wdt_rst     (wdt_rst)
);

// File: tb/guard_timer_test.sv
module guard_timer_test;
   logic        bus_clk = 1'b0;
   logic        slow_clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic        wdt_rst;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   localparam logic [31:0] DEFL = 32'hFFFF_F000;

   always #2 bus_clk = ~bus_clk;
   always #20 slow_clk = ~slow_clk;

   guard_timer uut (
      .bus_clk(bus_clk), .slow_clk(slow_clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .wdt_rst(wdt_rst)
   );

   task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_rng(input string req, input logic [31:0] act,
                          input logic [31:0] lo, input logic [31:0] hi);
      checks++;
      if (act < lo || act > hi) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h..%h", req, act, lo, hi);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge bus_clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge bus_clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
      @(negedge bus_clk);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] p;
      for (int i = 0; i < 400; i++) begin
         bus_read(3'd6, p);
         if (p == 32'h0) return;
      end
      chk_eq("R5 pending never cleared", p, 32'h0);
   endtask

   task automatic put(input logic [2:0] a, input logic [31:0] d);
      bus_write(a, d);
      wait_idle();
   endtask

   task automatic slow_wait(input int n);
      repeat (n) @(negedge slow_clk);
   endtask

   task automatic read_cnt(output logic [31:0] c);
      slow_wait(6);
      bus_read(3'd2, c);
   endtask

   task automatic t_reset();
      logic [31:0] d, c1, c2;
      bus_read(3'd6, d);
      chk_eq("R1 pending after reset", d, 32'h0);
      bus_read(3'd0, d);
      chk_eq("R1 revision code", d & 32'hFF, 32'h3A);
      read_cnt(c1);
      chk_rng("R1 counter near default load", c1, DEFL, DEFL + 32'd40);
      slow_wait(20);
      bus_read(3'd2, c2);
      chk_rng("R9 counter advances after reset", c2, c1 + 32'd15, c1 + 32'd25);
   endtask

   task automatic t_pending();
      logic [31:0] p;
      bus_write(3'd4, 32'h1234);
      bus_read(3'd6, p);
      chk_eq("R5 trigger busy bit 3", p, 32'h8);
      wait_idle();
      bus_read(3'd6, p);
      chk_eq("R5 busy clears after handshake", p, 32'h0);
   endtask

   task automatic t_stop();
      logic [31:0] c1, c2;
      put(3'd5, 32'hAAAA); put(3'd5, 32'h1111); put(3'd5, 32'h5555);
      read_cnt(c1); slow_wait(20); bus_read(3'd2, c2);
      chk_rng("R4 broken stop keeps running", c2, c1 + 32'd15, c1 + 32'd25);
      put(3'd5, 32'hAAAA); put(3'd5, 32'h5555);
      read_cnt(c1); slow_wait(20); bus_read(3'd2, c2);
      chk_eq("R3 stop sequence freezes counter", c2, c1);
   endtask

   task automatic t_config_stopped();
      logic [31:0] p, c;
      bus_write(3'd1, 32'h0);
      bus_write(3'd3, 32'h100);
      bus_read(3'd6, p);
      chk_eq("R5 control and load busy bits", p, 32'h5);
      wait_idle();
      put(3'd4, 32'h5678);
      read_cnt(c);
      chk_eq("R6 fresh trigger reloads load value", c, 32'h100);
   endtask

   task automatic t_bad_start();
      logic [31:0] c;
      put(3'd5, 32'h4444);
      slow_wait(20); read_cnt(c);
      chk_eq("R4 lone second word ignored", c, 32'h100);
      put(3'd5, 32'hBBBB); put(3'd5, 32'h0000); put(3'd5, 32'h4444);
      slow_wait(20); read_cnt(c);
      chk_eq("R4 interrupted start ignored", c, 32'h100);
   endtask

   task automatic t_start_trigger();
      logic [31:0] c1, c2, c3;
      put(3'd5, 32'hBBBB); put(3'd5, 32'h4444);
      slow_wait(200);
      bus_read(3'd2, c1);
      chk_rng("R2 start sequence runs counter", c1, 32'h100 + 32'd180, 32'h100 + 32'd230);
      put(3'd4, 32'h5678);
      read_cnt(c2);
      chk_rng("R6 repeated trigger value no reload", c2, c1, c1 + 32'd40);
      put(3'd4, ~32'h5678);
      read_cnt(c3);
      chk_rng("R6 alternated trigger reloads", c3, 32'h100, 32'h100 + 32'd40);
   endtask

   task automatic t_ignored_running();
      logic [31:0] c1, c2, c3;
      put(3'd3, 32'h8000_0000);
      put(3'd1, 32'h3C);
      bus_read(3'd2, c1); slow_wait(100); bus_read(3'd2, c2);
      chk_rng("R8 control write ignored while running", c2 - c1, 32'd90, 32'd110);
      put(3'd4, 32'hA5A5);
      read_cnt(c3);
      chk_rng("R8 load write ignored while running", c3, 32'h100, 32'h100 + 32'd40);
   endtask

   task automatic t_prescale();
      logic [31:0] c1, c2;
      put(3'd5, 32'hAAAA); put(3'd5, 32'h5555);
      put(3'd1, 32'h28);
      put(3'd4, 32'h1111);
      put(3'd5, 32'hBBBB); put(3'd5, 32'h4444);
      bus_read(3'd2, c1); slow_wait(400); bus_read(3'd2, c2);
      chk_rng("R7 prescaler divides by four", c2 - c1, 32'd97, 32'd103);
   endtask

   task automatic measure_period(input string req, input int exp_n);
      int n;
      n = 0;
      for (int i = 0; i < 3000; i++) begin
         @(negedge slow_clk);
         if (wdt_rst) break;
      end
      chk_eq({req, " first pulse seen"}, 32'(wdt_rst), 32'd1);
      for (int i = 0; i < 3000; i++) begin
         @(negedge slow_clk);
         n++;
         if (n == 1) chk_eq({req, " pulse one slow clock"}, 32'(wdt_rst), 32'd0);
         if (wdt_rst) break;
      end
      chk_eq({req, " pulse interval"}, 32'(n), 32'(exp_n));
   endtask

   task automatic t_overflow();
      put(3'd5, 32'hAAAA); put(3'd5, 32'h5555);
      put(3'd1, 32'h0);
      put(3'd3, 32'hFFFF_FFF0);
      put(3'd4, 32'h2222);
      put(3'd5, 32'hBBBB); put(3'd5, 32'h4444);
      measure_period("R10 wrap no prescale", 16);
      put(3'd5, 32'hAAAA); put(3'd5, 32'h5555);
      put(3'd1, 32'h28);
      put(3'd4, 32'h3333);
      put(3'd5, 32'hBBBB); put(3'd5, 32'h4444);
      measure_period("R10 R7 wrap with prescale", 64);
      put(3'd5, 32'hAAAA); put(3'd5, 32'h5555);
   endtask

   initial begin
      #600000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #103 rst_n = 1'b1;
      t_reset();
      t_pending();
      t_stop();
      t_config_stopped();
      t_bad_start();
      t_start_trigger();
      t_ignored_running();
      t_prescale();
      t_overflow();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule